// File: doc/BRIEF.md
# Power-Up Memory Boot Sequencer

After the active-low reset is released, this block walks one shared address counter through a fixed start-up window. Along the way it copies a program boot ROM into the program RAM and a parameter boot ROM into the parameter RAM, and it writes zeros across the whole data RAM. All three RAM write ports are driven in parallel, one address per clock. Each memory stops when it reaches its own depth.

The block also owns the bank of host-visible control registers. The bank is zero after reset and stays zero for the whole window. The window has a fixed length set by a parameter (1024 master clocks by default), whatever the clock frequency. When it ends, `done` rises and `busy` falls. Only then do host writes to the control bank take effect. Asserting reset at any point aborts the sequence, and it starts again from address 0.

Both boot ROMs are synchronous constant tables computed inside the design. Word bit i at address a equals a[i mod AW] XOR ((i div AW) mod 2) XOR S, where AW is the ROM's address width, S = 0 for the program ROM and S = 1 for the parameter ROM.

Top module: `boot_seq`

## Requirements
- R1: While reset is low, all three write enables are 0, `done` is 0, `busy` is 1 and every control register reads 0.
- R2: In the k-th cycle after reset release (k = 1 … PROG_DEPTH), `prog_we` is 1, `prog_addr` is k−1 and `prog_wdata` is the program ROM word for k−1. Outside those cycles `prog_we` is 0.
- R3: In cycles k = 1 … PARAM_DEPTH, `param_we` is 1, `param_addr` is k−1 and `param_wdata` is the parameter ROM word for k−1. Parameter writes then stop while program writes continue.
- R4: In cycles k = 1 … DATA_DEPTH, `data_we` is 1 and `data_addr` is k−1, with `data_wdata` equal to zero.
- R5: Every control register reads zero after any reset, even if it held host data before.
- R6: `done` first reads 1 exactly BOOT_CYCLES clocks after reset release and stays 1 until the next reset. `busy` is always its inverse.
- R7: Host writes presented while `busy` is 1 leave every control register at zero.
- R8: Once `done` is 1, a host write with `host_we`=1 loads `host_wdata` into register `host_sel`, and the new value is visible on the following cycle.
- R9: Reset asserted mid-sequence drops every write enable at once. After release, the sequence restarts from address 0 with the full window length.
- R10: Over one complete sequence, each address of each RAM is written exactly once, and no RAM write occurs once `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the sequence |
| host_we | input | 1 | Host control-register write strobe |
| host_sel | input | $clog2(NUM_CTRL) | Control register index |
| host_wdata | input | CTRL_W | Host write data |
| prog_we | output | 1 | Program RAM write enable |
| prog_addr | output | $clog2(PROG_DEPTH) | Program RAM address |
| prog_wdata | output | PROG_W | Program RAM write data |
| param_we | output | 1 | Parameter RAM write enable |
| param_addr | output | $clog2(PARAM_DEPTH) | Parameter RAM address |
| param_wdata | output | PARAM_W | Parameter RAM write data |
| data_we | output | 1 | Data RAM write enable |
| data_addr | output | $clog2(DATA_DEPTH) | Data RAM address |
| data_wdata | output | DATA_W | Data RAM write data (always zero) |
| ctrl_regs | output | NUM_CTRL*CTRL_W | Packed control register bank, register 0 in the low bits |
| busy | output | 1 | High until the start-up window ends |
| done | output | 1 | High once the start-up window has ended |

## Verification
The bench builds the block with a 32-word program RAM, a 16-word parameter RAM, a 24-word data RAM, four 8-bit control registers and a 64-cycle window, keeping the full data widths. At this size every address of all three memories is checked in every cycle of several complete sequences. The three different depths show that each memory stops on its own boundary. The short window brings the exact `done` edge, the host lockout at both edges of `busy`, and a mid-sequence abort and restart into easy reach.

// File: rtl/boot_pkg.sv
package boot_pkg;

    // Constant ROM pattern: bit i = addr[i % aw] ^ ((i / aw) & 1) ^ salt
    function automatic logic [63:0] boot_rom_word(input int unsigned addr,
                                                  input int unsigned aw,
                                                  input int unsigned width,
                                                  input bit salt);
        logic [63:0] w;
        w = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < width) begin
                w[i] = ((addr >> (i % aw)) & 1) != 0;
                w[i] = w[i] ^ (((i / aw) & 1) != 0) ^ salt;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/boot_rom.sv
module boot_rom #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 35,
    parameter bit SALT  = 1'b0,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr,
    output logic [WIDTH-1:0] data
);
    import boot_pkg::*;

    logic [WIDTH-1:0] data_d;
    logic [WIDTH-1:0] data_q;

    always_comb begin
        data_d = WIDTH'(boot_rom_word(int'(addr), AW, WIDTH, SALT));
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign data = data_q;
endmodule

// File: rtl/boot_ctrl_bank.sv
module boot_ctrl_bank #(
    parameter int NUM_CTRL = 2,
    parameter int CTRL_W   = 16,
    localparam int SELW    = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       wr_en,
    input  logic [SELW-1:0]            wr_sel,
    input  logic [CTRL_W-1:0]          wr_data,
    output logic [NUM_CTRL*CTRL_W-1:0] regs
);
    logic [NUM_CTRL-1:0][CTRL_W-1:0] bank_d;
    logic [NUM_CTRL-1:0][CTRL_W-1:0] bank_q;

    always_comb begin
        bank_d = bank_q;
        if (lock) begin
            bank_d = '0;
        end else if (wr_en) begin
            for (int r = 0; r < NUM_CTRL; r++) begin
                if (wr_sel == SELW'(r)) begin
                    bank_d[r] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q;
endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
    parameter int PROG_DEPTH  = 512,
    parameter int PROG_W      = 35,
    parameter int PARAM_DEPTH = 256,
    parameter int PARAM_W     = 22,
    parameter int DATA_DEPTH  = 512,
    parameter int DATA_W      = 26,
    parameter int BOOT_CYCLES = 1024,
    parameter int NUM_CTRL    = 2,
    parameter int CTRL_W      = 16,
    localparam int PAW  = $clog2(PROG_DEPTH),
    localparam int RAW  = $clog2(PARAM_DEPTH),
    localparam int DAW  = $clog2(DATA_DEPTH),
    localparam int SELW = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [SELW-1:0]            host_sel,
    input  logic [CTRL_W-1:0]          host_wdata,
    output logic                       prog_we,
    output logic [PAW-1:0]             prog_addr,
    output logic [PROG_W-1:0]          prog_wdata,
    output logic                       param_we,
    output logic [RAW-1:0]             param_addr,
    output logic [PARAM_W-1:0]         param_wdata,
    output logic                       data_we,
    output logic [DAW-1:0]             data_addr,
    output logic [DATA_W-1:0]          data_wdata,
    output logic [NUM_CTRL*CTRL_W-1:0] ctrl_regs,
    output logic                       busy,
    output logic                       done
);
    localparam int WAW0 = (PAW > DAW) ? PAW : DAW;
    localparam int WAW  = (WAW0 > RAW) ? WAW0 : RAW;
    localparam int CW   = $clog2(BOOT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0]  cyc;
        logic           fin;
        logic           pg_we;
        logic           pr_we;
        logic           dt_we;
        logic [WAW-1:0] wa;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.fin) begin
            seq_d.cyc = seq_q.cyc + CW'(1);
        end
        seq_d.fin   = seq_q.fin | (seq_q.cyc == CW'(BOOT_CYCLES - 1));
        seq_d.pg_we = !seq_q.fin && (seq_q.cyc < CW'(PROG_DEPTH));
        seq_d.pr_we = !seq_q.fin && (seq_q.cyc < CW'(PARAM_DEPTH));
        seq_d.dt_we = !seq_q.fin && (seq_q.cyc < CW'(DATA_DEPTH));
        seq_d.wa    = seq_q.cyc[WAW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    boot_rom #(.DEPTH(PROG_DEPTH), .WIDTH(PROG_W), .SALT(1'b0)) u_prog_rom (
        .clk  (clk),
        .addr (seq_q.cyc[PAW-1:0]),
        .data (prog_wdata)
    );

    boot_rom #(.DEPTH(PARAM_DEPTH), .WIDTH(PARAM_W), .SALT(1'b1)) u_param_rom (
        .clk  (clk),
        .addr (seq_q.cyc[RAW-1:0]),
        .data (param_wdata)
    );

    boot_ctrl_bank #(.NUM_CTRL(NUM_CTRL), .CTRL_W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (!seq_q.fin),
        .wr_en   (host_we),
        .wr_sel  (host_sel),
        .wr_data (host_wdata),
        .regs    (ctrl_regs)
    );

    assign prog_we    = seq_q.pg_we;
    assign param_we   = seq_q.pr_we;
    assign data_we    = seq_q.dt_we;
    assign prog_addr  = seq_q.wa[PAW-1:0];
    assign param_addr = seq_q.wa[RAW-1:0];
    assign data_addr  = seq_q.wa[DAW-1:0];
    assign data_wdata = '0;
    assign done       = seq_q.fin;
    assign busy       = !seq_q.fin;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
    parameter int PAW = 9,
    parameter int RAW = 8,
    parameter int DAW = 9,
    parameter int DATA_W = 26,
    parameter int CTRL_BITS = 32,
    parameter int BOOT_CYCLES = 1024
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 prog_we,
    input logic [PAW-1:0]       prog_addr,
    input logic                 param_we,
    input logic [RAW-1:0]       param_addr,
    input logic                 data_we,
    input logic [DATA_W-1:0]    data_wdata,
    input logic [CTRL_BITS-1:0] ctrl_regs,
    input logic                 busy,
    input logic                 done
);
    localparam int CW = $clog2(BOOT_CYCLES + 1);
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != CW'(BOOT_CYCLES)) begin
            since_q <= since_q + CW'(1);
        end
    end

    assert_done_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done == (since_q == CW'(BOOT_CYCLES)));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_busy_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy != done);

    assert_prog_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && $past(prog_we)) |-> (prog_addr == $past(prog_addr) + PAW'(1)));

    assert_first_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_we) |-> (prog_addr == '0));

    assert_param_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        param_we |-> (prog_we && (param_addr == prog_addr[RAW-1:0])));

    assert_data_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |-> (data_wdata == '0));

    assert_quiet_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(prog_we || param_we || data_we));

    assert_ctrl_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctrl_regs == '0));
endmodule

bind boot_seq boot_seq_chk #(
    .PAW(PAW), .RAW(RAW), .DAW(DAW), .DATA_W(DATA_W),
    .CTRL_BITS(NUM_CTRL*CTRL_W), .BOOT_CYCLES(BOOT_CYCLES)
) u_boot_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .param_we   (param_we),
    .param_addr (param_addr),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .ctrl_regs  (ctrl_regs),
    .busy       (busy),
    .done       (done)
);

// File: tb/boot_seq_test.sv
module boot_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PD = 32, PW = 35, RD = 16, RW = 22, DD = 24, DW = 26;
    localparam int BOOT = 64, NC = 4, CWD = 8;
    localparam int PAW = $clog2(PD), RAW = $clog2(RD), DAW = $clog2(DD), SELW = $clog2(NC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [SELW-1:0] host_sel = '0;
    logic [CWD-1:0] host_wdata = '0;
    logic prog_we, param_we, data_we, busy, done;
    logic [PAW-1:0] prog_addr;
    logic [RAW-1:0] param_addr;
    logic [DAW-1:0] data_addr;
    logic [PW-1:0] prog_wdata;
    logic [RW-1:0] param_wdata;
    logic [DW-1:0] data_wdata;
    logic [NC*CWD-1:0] ctrl_regs;

    int total = 0;
    int bad = 0;
    int prog_hits[PD];
    int param_hits[RD];
    int data_hits[DD];

    boot_seq #(.PROG_DEPTH(PD), .PROG_W(PW), .PARAM_DEPTH(RD), .PARAM_W(RW),
               .DATA_DEPTH(DD), .DATA_W(DW), .BOOT_CYCLES(BOOT),
               .NUM_CTRL(NC), .CTRL_W(CWD)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .param_we(param_we), .param_addr(param_addr),
        .param_wdata(param_wdata), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .ctrl_regs(ctrl_regs), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] rom_exp(input int a, input int aw, input int w, input int s);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = (((a >> (i % aw)) ^ (i / aw) ^ s) & 1) != 0;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_hits();
        for (int i = 0; i < PD; i++) prog_hits[i] = 0;
        for (int i = 0; i < RD; i++) param_hits[i] = 0;
        for (int i = 0; i < DD; i++) data_hits[i] = 0;
    endtask

    // Hold reset, check reset state, release at a falling edge
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!prog_we && !param_we && !data_we, "R1 we", {prog_we, param_we, data_we}, 0);
        chk(!done && busy, "R1 done/busy", {done, busy}, 1);
        chk(ctrl_regs == '0, "R5 ctrl after reset", ctrl_regs, 0);
        rst_n = 1'b1;
    endtask

    // Run up to last_k cycles after release; host hammers the bank while busy
    task automatic run_seq(input int last_k);
        bit okp = 1, okr = 1, okd = 1, okdn = 1;
        for (int k = 1; k <= last_k; k++) begin
            @(negedge clk);
            if (prog_we) prog_hits[prog_addr]++;
            if (param_we) param_hits[param_addr]++;
            if (data_we) data_hits[data_addr]++;
            if (k <= PD) begin
                if (!(prog_we && prog_addr == PAW'(k-1) && prog_wdata == PW'(rom_exp(k-1, PAW, PW, 0)))) begin
                    okp = 0;
                    chk(0, "R2 prog write", {prog_we, prog_addr, prog_wdata}, rom_exp(k-1, PAW, PW, 0));
                end
            end else if (prog_we) begin
                okp = 0; chk(0, "R2 prog idle", 1, 0);
            end
            if (k <= RD) begin
                if (!(param_we && param_addr == RAW'(k-1) && param_wdata == RW'(rom_exp(k-1, RAW, RW, 1)))) begin
                    okr = 0;
                    chk(0, "R3 param write", {param_we, param_addr, param_wdata}, rom_exp(k-1, RAW, RW, 1));
                end
            end else if (param_we) begin
                okr = 0; chk(0, "R3 param idle", 1, 0);
            end
            if (k <= DD) begin
                if (!(data_we && data_addr == DAW'(k-1) && data_wdata == '0)) begin
                    okd = 0; chk(0, "R4 data write", {data_we, data_addr, data_wdata}, k-1);
                end
            end else if (data_we) begin
                okd = 0; chk(0, "R4 data idle", 1, 0);
            end
            if (done != (k >= BOOT) || busy == done) begin
                okdn = 0; chk(0, "R6 done timing", {done, busy}, (k >= BOOT) ? 2 : 1);
            end
            host_we = (k + 1 <= BOOT);
            host_sel = SELW'(k % NC);
            host_wdata = '1;
        end
        host_we = 1'b0;
        chk(okp, "R2 prog sweep", 0, 0);
        chk(okr, "R3 param sweep", 0, 0);
        chk(okd, "R4 data sweep", 0, 0);
        chk(okdn, "R6 done sweep", 0, 0);
    endtask

    task automatic check_once();
        bit ok = 1;
        for (int i = 0; i < PD; i++) if (prog_hits[i] != 1) ok = 0;
        chk(ok, "R10 prog once", 0, 1);
        ok = 1;
        for (int i = 0; i < RD; i++) if (param_hits[i] != 1) ok = 0;
        chk(ok, "R10 param once", 0, 1);
        ok = 1;
        for (int i = 0; i < DD; i++) if (data_hits[i] != 1) ok = 0;
        chk(ok, "R10 data once", 0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // Full boot
        clear_hits();
        do_reset();
        run_seq(BOOT + 4);
        check_once();
        chk(ctrl_regs == '0, "R7 host locked out", ctrl_regs, 0);

        // Host writes after done
        for (int r = 0; r < NC; r++) begin
            host_we = 1'b1; host_sel = SELW'(r); host_wdata = CWD'(r * 37 + 5);
            @(negedge clk);
            host_we = 1'b0;
            chk(ctrl_regs[r*CWD +: CWD] == CWD'(r * 37 + 5), "R8 host write",
                ctrl_regs[r*CWD +: CWD], r * 37 + 5);
        end

        // Abort mid-sequence, then restart
        clear_hits();
        do_reset();
        run_seq(10);
        rst_n = 1'b0;
        #1;
        chk(!prog_we && !param_we && !data_we, "R9 abort drops we", {prog_we, param_we, data_we}, 0);
        clear_hits();
        do_reset();
        run_seq(BOOT + 2);
        check_once();
        chk(done && ctrl_regs == '0, "R9 restart complete", {done, ctrl_regs}, 1 << (NC*CWD));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule